// File: doc/BRIEF.md
# Indirect-Addressed Synaptic Input Fetch Unit

This block delivers presynaptic neuron outputs to a pipelined neuron datapath, one synapse bunch per clock. It holds `LANES` identical lanes. Each lane pairs a connection table with a value store. The connection table maps a bunch number to a neuron index. The value store maps a neuron index to that neuron's latest output. A single bunch number goes to every connection table in the same cycle, so the lanes together return all presynaptic values of that bunch at once. The whole network topology sits in the connection tables. For lane `k`, entry `b` names the neuron that feeds synapse `(b*LANES + k) mod (bpn*LANES)` of neuron `b / bpn`, where `bpn` is the number of bunches per neuron.

Newly computed neuron outputs arrive on one shared write port that updates every value store together. This port stays usable while fetches continue. A separate load port fills the connection tables before the fetch stream starts. Synapse slots that a neuron's last bunch leaves unused point at a reserved neuron index. That index always reads as zero, so the unused slots add nothing downstream.

Top module: `syn_fetch_unit`

## Requirements
- R1: A bunch request sampled with `fetch_valid_i` high at clock edge t produces `out_valid_o` high after edge t+1, so the output is registered two edges after the request. `out_valid_o` never rises without a matching request.
- R2: When `out_valid_o` is high, bits `[k*DATA_W +: DATA_W]` of `out_data_o` hold the value store entry that lane k's connection table names at the requested bunch. All lanes use the same bunch number.
- R3: One write on the shared port (index, value) updates the value store of every lane, so later fetches return the new value in any lane that references that index.
- R4: If a write to neuron n is sampled at the same edge at which a lane reads neuron n from its value store (one edge after the request), the fetch returns the value from before the write.
- R5: The reserved index `NEURONS-1` always reads as zero. Writes to it have no effect.
- R6: A load with `ld_en_i` high writes `ld_data_i` into entry `ld_addr_i` of the connection table of lane `ld_lane_i`. A load issued in a cycle where `fetch_valid_i` is high is discarded.
- R7: `out_data_o` is all zero whenever `out_valid_o` is low.
- R8: While `rst_n` is low, `out_valid_o` and `out_data_o` are zero.
- R9: Requests on consecutive cycles give results on consecutive cycles, one bunch per clock, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Bunch request strobe |
| bunch_i | input | $clog2(BUNCHES) | Bunch number sent to all connection tables |
| out_valid_o | output | 1 | Presynaptic values valid |
| out_data_o | output | LANES*DATA_W | Presynaptic values, lane k in slice k |
| wr_en_i | input | 1 | Shared value write strobe |
| wr_idx_i | input | $clog2(NEURONS) | Neuron index to update |
| wr_val_i | input | DATA_W | New neuron output |
| ld_en_i | input | 1 | Connection table load strobe |
| ld_lane_i | input | $clog2(LANES) | Lane whose table is loaded |
| ld_addr_i | input | $clog2(BUNCHES) | Table entry to load |
| ld_data_i | input | $clog2(NEURONS) | Neuron index to store |

## Verification
The hardest case to reach is the collision between a neuron update and a value-store read of the same neuron. The write has to land exactly one edge after the bunch request, and that edge is not visible at the ports. The stimulus issues a request for a bunch whose lane 0 entry names a known neuron, writes that neuron on the next cycle, and then requests the same bunch again. The first result must show the old value and the second the new one. A load that collides with a request is also forced, and the discarded entry is read back through a later fetch.

// File: rtl/syn_fetch_pkg.sv
package syn_fetch_pkg;

    localparam int unsigned DEF_LANES   = 4;
    localparam int unsigned DEF_NEURONS = 32;
    localparam int unsigned DEF_BUNCHES = 16;
    localparam int unsigned DEF_DATA_W  = 8;

    typedef struct packed {
        logic stage1;
        logic stage2;
    } valid_pipe_t;

    function automatic int unsigned reserved_index(int unsigned neurons);
        return neurons - 1;
    endfunction

endpackage

// File: rtl/syn_conn_mem.sv
module syn_conn_mem #(
    parameter int unsigned BUNCHES = 16,
    parameter int unsigned NEURONS = 32,
    localparam int unsigned BW = (BUNCHES > 1) ? $clog2(BUNCHES) : 1,
    localparam int unsigned NW = (NEURONS > 1) ? $clog2(NEURONS) : 1
) (
    input  logic          clk,
    input  logic          ld_en_i,
    input  logic [BW-1:0] ld_addr_i,
    input  logic [NW-1:0] ld_data_i,
    input  logic [BW-1:0] rd_addr_i,
    output logic [NW-1:0] rd_data_o
);

    logic [NW-1:0] table_q [BUNCHES];

    always_ff @(posedge clk) begin
        if (ld_en_i) begin
            table_q[ld_addr_i] <= ld_data_i;
        end
    end

    assign rd_data_o = table_q[rd_addr_i];

endmodule

// File: rtl/syn_val_mem.sv
module syn_val_mem
    import syn_fetch_pkg::*;
#(
    parameter int unsigned NEURONS = 32,
    parameter int unsigned DATA_W  = 8,
    localparam int unsigned NW = (NEURONS > 1) ? $clog2(NEURONS) : 1,
    localparam logic [NW-1:0] ZERO_IDX = NW'(reserved_index(NEURONS))
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [NW-1:0]     wr_idx_i,
    input  logic [DATA_W-1:0] wr_val_i,
    input  logic [NW-1:0]     rd_idx_i,
    output logic [DATA_W-1:0] rd_val_o
);

    logic [DATA_W-1:0] store_q [NEURONS];

    // Reserved index is never written; reads of it are forced to zero.
    always_ff @(posedge clk) begin
        if (wr_en_i && (wr_idx_i != ZERO_IDX)) begin
            store_q[wr_idx_i] <= wr_val_i;
        end
    end

    // Combinational read sees the pre-edge content: a same-edge write
    // lands after the read is captured downstream.
    assign rd_val_o = (rd_idx_i == ZERO_IDX) ? '0 : store_q[rd_idx_i];

endmodule

// File: rtl/syn_fetch_lane.sv
module syn_fetch_lane #(
    parameter int unsigned BUNCHES = 16,
    parameter int unsigned NEURONS = 32,
    parameter int unsigned DATA_W  = 8,
    localparam int unsigned BW = (BUNCHES > 1) ? $clog2(BUNCHES) : 1,
    localparam int unsigned NW = (NEURONS > 1) ? $clog2(NEURONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [BW-1:0]     bunch_i,
    input  logic              stage1_valid_i,
    input  logic              wr_en_i,
    input  logic [NW-1:0]     wr_idx_i,
    input  logic [DATA_W-1:0] wr_val_i,
    input  logic              ld_en_i,
    input  logic [BW-1:0]     ld_addr_i,
    input  logic [NW-1:0]     ld_data_i,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic [NW-1:0]     idx;
        logic [DATA_W-1:0] data;
    } lane_st_t;

    lane_st_t st_d, st_q;

    logic [NW-1:0]     conn_rd;
    logic [DATA_W-1:0] val_rd;

    syn_conn_mem #(
        .BUNCHES (BUNCHES),
        .NEURONS (NEURONS)
    ) u_conn (
        .clk       (clk),
        .ld_en_i   (ld_en_i),
        .ld_addr_i (ld_addr_i),
        .ld_data_i (ld_data_i),
        .rd_addr_i (bunch_i),
        .rd_data_o (conn_rd)
    );

    syn_val_mem #(
        .NEURONS (NEURONS),
        .DATA_W  (DATA_W)
    ) u_val (
        .clk      (clk),
        .wr_en_i  (wr_en_i),
        .wr_idx_i (wr_idx_i),
        .wr_val_i (wr_val_i),
        .rd_idx_i (st_q.idx),
        .rd_val_o (val_rd)
    );

    always_comb begin
        st_d = st_q;
        if (req_valid_i) begin
            st_d.idx = conn_rd;
        end
        st_d.data = stage1_valid_i ? val_rd : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;

endmodule

// File: rtl/syn_fetch_unit.sv
module syn_fetch_unit
    import syn_fetch_pkg::*;
#(
    parameter int unsigned LANES   = DEF_LANES,
    parameter int unsigned NEURONS = DEF_NEURONS,
    parameter int unsigned BUNCHES = DEF_BUNCHES,
    parameter int unsigned DATA_W  = DEF_DATA_W,
    localparam int unsigned BW = (BUNCHES > 1) ? $clog2(BUNCHES) : 1,
    localparam int unsigned NW = (NEURONS > 1) ? $clog2(NEURONS) : 1,
    localparam int unsigned LW = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned OUT_W = LANES * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid_i,
    input  logic [BW-1:0]     bunch_i,
    output logic              out_valid_o,
    output logic [OUT_W-1:0]  out_data_o,
    input  logic              wr_en_i,
    input  logic [NW-1:0]     wr_idx_i,
    input  logic [DATA_W-1:0] wr_val_i,
    input  logic              ld_en_i,
    input  logic [LW-1:0]     ld_lane_i,
    input  logic [BW-1:0]     ld_addr_i,
    input  logic [NW-1:0]     ld_data_i
);

    valid_pipe_t vp_d, vp_q;

    always_comb begin
        vp_d        = vp_q;
        vp_d.stage1 = fetch_valid_i;
        vp_d.stage2 = vp_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vp_q <= '0;
        end else begin
            vp_q <= vp_d;
        end
    end

    // Loads are accepted only while no request is presented.
    logic ld_ok;
    assign ld_ok = ld_en_i && !fetch_valid_i;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic lane_ld;
        assign lane_ld = ld_ok && (ld_lane_i == LW'(k));

        syn_fetch_lane #(
            .BUNCHES (BUNCHES),
            .NEURONS (NEURONS),
            .DATA_W  (DATA_W)
        ) u_lane (
            .clk            (clk),
            .rst_n          (rst_n),
            .req_valid_i    (fetch_valid_i),
            .bunch_i        (bunch_i),
            .stage1_valid_i (vp_q.stage1),
            .wr_en_i        (wr_en_i),
            .wr_idx_i       (wr_idx_i),
            .wr_val_i       (wr_val_i),
            .ld_en_i        (lane_ld),
            .ld_addr_i      (ld_addr_i),
            .ld_data_i      (ld_data_i),
            .data_o         (out_data_o[k*DATA_W +: DATA_W])
        );
    end

    assign out_valid_o = vp_q.stage2;

endmodule

// File: rtl/syn_fetch_checker.sv
module syn_fetch_checker #(
    parameter int unsigned OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_valid_i,
    input logic             out_valid_o,
    input logic [OUT_W-1:0] out_data_o
);

    logic [1:0] since_rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else if (since_rst_q != 2'd2) begin
            since_rst_q <= since_rst_q + 2'd1;
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd2) |-> (out_valid_o == $past(fetch_valid_i, 2)));

    assert_valid_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(out_valid_o));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (out_data_o == '0));

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid_o && (out_data_o == '0)));

endmodule

bind syn_fetch_unit syn_fetch_checker #(.OUT_W(OUT_W)) u_fetch_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid_i (fetch_valid_i),
    .out_valid_o   (out_valid_o),
    .out_data_o    (out_data_o)
);

// File: tb/tb_syn_fetch_unit.sv
module tb_syn_fetch_unit;

    localparam int unsigned LANES   = 4;
    localparam int unsigned NEURONS = 32;
    localparam int unsigned BUNCHES = 16;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned BW = $clog2(BUNCHES);
    localparam int unsigned NW = $clog2(NEURONS);
    localparam int unsigned LW = $clog2(LANES);
    localparam int unsigned OUT_W = LANES * DATA_W;
    localparam int unsigned ZERO = NEURONS - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_valid_i = 1'b0;
    logic [BW-1:0]     bunch_i = '0;
    logic              out_valid_o;
    logic [OUT_W-1:0]  out_data_o;
    logic              wr_en_i = 1'b0;
    logic [NW-1:0]     wr_idx_i = '0;
    logic [DATA_W-1:0] wr_val_i = '0;
    logic              ld_en_i = 1'b0;
    logic [LW-1:0]     ld_lane_i = '0;
    logic [BW-1:0]     ld_addr_i = '0;
    logic [NW-1:0]     ld_data_i = '0;

    always #2.5 clk = ~clk;

    syn_fetch_unit #(
        .LANES(LANES), .NEURONS(NEURONS), .BUNCHES(BUNCHES), .DATA_W(DATA_W)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid_i(fetch_valid_i), .bunch_i(bunch_i),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_val_i(wr_val_i),
        .ld_en_i(ld_en_i), .ld_lane_i(ld_lane_i), .ld_addr_i(ld_addr_i),
        .ld_data_i(ld_data_i)
    );

    typedef struct {
        logic [OUT_W-1:0] data;
        int               due;
        string            tag;
    } exp_t;

    exp_t               sb_q[$];
    logic [NW-1:0]      conn_m [LANES][BUNCHES];
    logic [DATA_W-1:0]  val_m  [NEURONS];
    int                 cyc = 0;
    int                 checks = 0;
    int                 errors = 0;
    bit                 done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [OUT_W-1:0] model_fetch(input int b);
        logic [OUT_W-1:0] r;
        r = '0;
        for (int k = 0; k < LANES; k++) begin
            if (conn_m[k][b] != NW'(ZERO)) r[k*DATA_W +: DATA_W] = val_m[conn_m[k][b]];
        end
        return r;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic issue(input int b, input string tag);
        exp_t e;
        fetch_valid_i = 1'b1;
        bunch_i = BW'(b);
        e.data = model_fetch(b);
        e.due  = cyc + 2;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        fetch_valid_i = 1'b0;
        wr_en_i = 1'b0;
        ld_en_i = 1'b0;
        repeat (n) step();
    endtask

    task automatic write_val(input int n, input logic [DATA_W-1:0] v);
        wr_en_i = 1'b1;
        wr_idx_i = NW'(n);
        wr_val_i = v;
        if (n != ZERO) val_m[n] = v;
    endtask

    // Monitor: pop expected items as results arrive.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid_o) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R1 unexpected valid", out_data_o, '0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(e.due == cyc, "R1 latency", OUT_W'(cyc), OUT_W'(e.due));
                    check(out_data_o == e.data, e.tag, out_data_o, e.data);
                end
            end else begin
                check(out_data_o == '0, "R7 idle data zero", out_data_o, '0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R1 watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < NEURONS; n++) val_m[n] = '0;
        repeat (3) step();
        check(!out_valid_o && out_data_o == '0, "R8 reset outputs",
              {out_valid_o, out_data_o[OUT_W-2:0]}, '0);
        step();
        rst_n = 1'b1;
        step();

        // Load all connection tables; some entries use the reserved index (R6, R5).
        for (int k = 0; k < LANES; k++) begin
            for (int b = 0; b < BUNCHES; b++) begin
                int t;
                t = ((b % 4) == 3 && k >= 2) ? ZERO : ((b * LANES + k * 5 + 1) % ZERO);
                conn_m[k][b] = NW'(t);
                ld_en_i = 1'b1;
                ld_lane_i = LW'(k);
                ld_addr_i = BW'(b);
                ld_data_i = NW'(t);
                step();
            end
        end
        ld_en_i = 1'b0;

        // Fill value stores, including an attempted write to the reserved index (R5).
        for (int n = 0; n < NEURONS; n++) begin
            write_val(n, (n == ZERO) ? 8'hAA : DATA_W'(n * 37 + 11));
            step();
        end
        idle(2);

        // Back-to-back stream over all bunches (R2, R9, R5 on reserved slots).
        for (int b = 0; b < BUNCHES; b++) begin
            issue(b, ((b % 4) == 3) ? "R5 reserved slot reads zero" : "R2 R9 stream");
            step();
        end
        idle(4);

        // Shared write reaches every lane (R3).
        write_val(conn_m[0][1], 8'h5C);
        step();
        write_val(conn_m[3][2], 8'hC3);
        step();
        idle(1);
        for (int b = 0; b < 4; b++) begin
            issue(b, "R3 shared write all lanes");
            step();
        end
        idle(4);

        // Same-cycle read/write collision returns old value (R4).
        issue(0, "R4 collision returns old value");
        step();
        fetch_valid_i = 1'b0;
        write_val(conn_m[0][0], 8'h77);
        step();
        wr_en_i = 1'b0;
        issue(0, "R4 value after collision");
        step();
        idle(4);

        // Load colliding with a request is discarded; idle load applies (R6).
        issue(2, "R6 fetch during load");
        ld_en_i = 1'b1;
        ld_lane_i = LW'(0);
        ld_addr_i = BW'(5);
        ld_data_i = NW'(7);
        step();
        fetch_valid_i = 1'b0;
        ld_lane_i = LW'(1);
        ld_data_i = NW'(9);
        conn_m[1][5] = NW'(9);
        step();
        ld_en_i = 1'b0;
        issue(5, "R6 load discarded and load applied");
        step();
        idle(5);

        check(sb_q.size() == 0, "R1 all results delivered",
              OUT_W'(sb_q.size()), '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule